// File: doc/BRIEF.md
# Board control register file

This block is a byte-wide board-management register file that hangs off a plain asynchronous parallel host bus. The bus has a chip select, a read strobe, a write strobe, a 4-bit address and 8-bit data. Through it the host reads fixed identification and version bytes and the live state of four banks of on-board DIP switches. It also controls which of eight flash boot banks drives the bank-select pins.

The boot bank normally follows a value supplied by physical switches. Software can store its own bank number and set an override bit, and from then on the stored number drives the pins instead. Two commands request a board reset through an active-low pulse of fixed length. The first is a preserving reset, which keeps every register, override included. The second is a restoring reset, which returns the writable registers to their defaults, so the next boot comes from the switch-selected bank.

The host strobes are brought into the block clock domain by a flip-flop synchroniser. Address and data are taken as stable while a strobe is asserted, and a write takes effect once, on the rising edge of the synchronised write strobe.

Top module: `board_ctl_regs`

## Requirements
- R1: Offsets 0x00, 0x01, 0x02, 0x03 and 0x04 read back the parameters ID_HI, ID_LO, VER_MAJOR, VER_MINOR and BOARD_REV. Writes to these offsets change nothing.
- R2: Offsets 0x07 and 0x0F read 0x00 even after they are written. rdata_o is 0x00 whenever no read is in progress.
- R3: Offset 0x05 is an 8-bit read/write override register with reset value 0x00. Its bit 2 selects the software bank.
- R4: Offset 0x08 stores a 3-bit bank number in bits [2:0]; bits [7:3] read as 0. When bit 2 of offset 0x05 is 1, bank_sel_o equals that stored number. When the bit is 0, bank_sel_o equals sw_bank_i.
- R5: Offsets 0x09, 0x0A, 0x0B and 0x0C return bytes [7:0], [15:8], [23:16] and [31:24] of sw_stat_i, passed through a two-stage synchroniser.
- R6: Offset 0x06 is an 8-bit read/write register whose reset and default value is RCW_DEFAULT.
- R7: A write commits only while chip select is asserted. It commits exactly once for each assertion of the write strobe, however long the strobe is held.
- R8: Writing 0x01 to offset 0x0D drives sys_rst_no low for RST_CYCLES clock cycles and leaves every register unchanged. Writing any other value to 0x0D has no effect.
- R9: Any write to offset 0x0E drives sys_rst_no low for RST_CYCLES cycles. When the pulse ends, offset 0x05 holds 0x00, offset 0x08 holds 0 and offset 0x06 holds RCW_DEFAULT.
- R10: Reset command writes that arrive while sys_rst_no is low are ignored: they neither extend the pulse nor start a second one.
- R11: Asserting rst_ni loads the default values into all writable registers and holds sys_rst_no high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Host chip select, active high, asynchronous |
| rd_i | input | 1 | Host read strobe, active high, asynchronous |
| wr_i | input | 1 | Host write strobe, active high, asynchronous |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0x00 when idle |
| sw_bank_i | input | 3 | Boot bank chosen by the physical switches |
| sw_stat_i | input | 32 | Four bytes of DIP switch state |
| bank_sel_o | output | 3 | Flash boot bank select |
| sys_rst_no | output | 1 | Board reset request, active low |

## Verification
The bench holds a write strobe for far longer than a reset pulse lasts. A design that detects the strobe level instead of its edge would fire a second reset there. The bench also sends reset commands while a pulse is in progress; a design that reloads its counter would produce a stretched pulse, and one that queues the command would produce an extra pulse. It writes 0x02 to the preserving-reset offset and writes with chip select low, and confirms at the ports that neither has any effect. Around both reset kinds it reads back the override, bank and configuration registers and the bank-select pins. A design that mixed up the two kinds would either lose the override after a preserving reset or keep it after a restoring one.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 8;
  localparam int BANK_W   = 3;
  localparam int SW_BANKS = 4;
  localparam int SW_W     = SW_BANKS * DATA_W;

  localparam logic [ADDR_W-1:0] A_ID_HI  = 4'h0;
  localparam logic [ADDR_W-1:0] A_ID_LO  = 4'h1;
  localparam logic [ADDR_W-1:0] A_VMAJ   = 4'h2;
  localparam logic [ADDR_W-1:0] A_VMIN   = 4'h3;
  localparam logic [ADDR_W-1:0] A_REV    = 4'h4;
  localparam logic [ADDR_W-1:0] A_OVR    = 4'h5;
  localparam logic [ADDR_W-1:0] A_RCW    = 4'h6;
  localparam logic [ADDR_W-1:0] A_BANK   = 4'h8;
  localparam logic [ADDR_W-1:0] A_SW0    = 4'h9;
  localparam logic [ADDR_W-1:0] A_RKEEP  = 4'hD;
  localparam logic [ADDR_W-1:0] A_RGLOB  = 4'hE;

  localparam int                OVR_BANK_BIT = 2;
  localparam logic [DATA_W-1:0] KEEP_CODE    = 8'h01;
endpackage

// File: rtl/cdc_sync.sv
module cdc_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= RST_VAL;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/reset_pulse.sv
module reset_pulse #(
  parameter int CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic glob_i,
  output logic rst_no,
  output logic reload_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          glob_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      glob_q <= 1'b0;
    end else if (cnt_q == '0) begin
      // idle: accept a new command only here
      if (req_i) begin
        cnt_q  <= CW'(CYCLES);
        glob_q <= glob_i;
      end
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign rst_no   = (cnt_q == '0);
  assign reload_o = glob_q && (cnt_q == CW'(1));
endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs
  import board_ctl_pkg::*;
#(
  parameter logic [7:0] ID_HI       = 8'h5A,
  parameter logic [7:0] ID_LO       = 8'hC3,
  parameter logic [7:0] VER_MAJOR   = 8'h01,
  parameter logic [7:0] VER_MINOR   = 8'h07,
  parameter logic [7:0] BOARD_REV   = 8'h0B,
  parameter logic [7:0] RCW_DEFAULT = 8'h1F,
  parameter int         RST_CYCLES  = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [BANK_W-1:0] sw_bank_i,
  input  logic [SW_W-1:0]   sw_stat_i,
  output logic [BANK_W-1:0] bank_sel_o,
  output logic              sys_rst_no
);
  logic [2:0]        strb_s;
  logic              cs_s, rd_s, wr_s, wr_d;
  logic [SW_W-1:0]   sw_s;
  logic              commit, rd_en;
  logic              rst_keep_req, rst_glob_req, rst_req, reload;
  logic [DATA_W-1:0] ovr_q, rcw_q, rd_mux, rdata_q;
  logic [BANK_W-1:0] bank_q;

  cdc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_strb_sync (
    .clk_i, .rst_ni, .d_i({cs_i, rd_i, wr_i}), .q_o(strb_s)
  );
  assign {cs_s, rd_s, wr_s} = strb_s;

  cdc_sync #(.WIDTH(SW_W), .STAGES(SYNC_STAGES)) i_sw_sync (
    .clk_i, .rst_ni, .d_i(sw_stat_i), .q_o(sw_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_d <= 1'b0;
    else         wr_d <= wr_s;
  end

  assign commit = wr_s && !wr_d && cs_s;
  assign rd_en  = rd_s && cs_s;

  assign rst_keep_req = commit && (addr_i == A_RKEEP) && (wdata_i == KEEP_CODE);
  assign rst_glob_req = commit && (addr_i == A_RGLOB);
  assign rst_req      = rst_keep_req || rst_glob_req;

  reset_pulse #(.CYCLES(RST_CYCLES)) i_rst_pulse (
    .clk_i, .rst_ni,
    .req_i   (rst_req),
    .glob_i  (rst_glob_req),
    .rst_no  (sys_rst_no),
    .reload_o(reload)
  );

  // restoring reset takes priority over a write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q  <= '0;
      rcw_q  <= RCW_DEFAULT;
      bank_q <= '0;
    end else if (reload) begin
      ovr_q  <= '0;
      rcw_q  <= RCW_DEFAULT;
      bank_q <= '0;
    end else if (commit) begin
      unique case (addr_i)
        A_OVR:   ovr_q  <= wdata_i;
        A_RCW:   rcw_q  <= wdata_i;
        A_BANK:  bank_q <= wdata_i[BANK_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      A_ID_HI: rd_mux = ID_HI;
      A_ID_LO: rd_mux = ID_LO;
      A_VMAJ:  rd_mux = VER_MAJOR;
      A_VMIN:  rd_mux = VER_MINOR;
      A_REV:   rd_mux = BOARD_REV;
      A_OVR:   rd_mux = ovr_q;
      A_RCW:   rd_mux = rcw_q;
      A_BANK:  rd_mux = {{(DATA_W-BANK_W){1'b0}}, bank_q};
      default: ;
    endcase
    for (int i = 0; i < SW_BANKS; i++) begin
      if (addr_i == A_SW0 + ADDR_W'(i)) rd_mux = sw_s[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_en ? rd_mux : '0;
  end

  assign rdata_o    = rdata_q;
  assign bank_sel_o = ovr_q[OVR_BANK_BIT] ? bank_q : sw_bank_i;
endmodule

// File: rtl/board_ctl_chk.sv
module board_ctl_chk #(
  parameter int RST_CYCLES = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sys_rst_no,
  input logic [2:0] bank_sel_o,
  input logic [2:0] sw_bank_i,
  input logic [7:0] ovr_q,
  input logic [2:0] bank_q,
  input logic       rst_req,
  input logic       rst_glob_req,
  input logic       commit,
  input logic       reload
);
  localparam int CW = $clog2(RST_CYCLES + 2);

  logic [CW-1:0] low_cnt;
  logic          pend_glob;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            low_cnt <= '0;
    else if (!sys_rst_no)   low_cnt <= (low_cnt == CW'(RST_CYCLES + 1)) ? low_cnt : low_cnt + 1'b1;
    else                    low_cnt <= '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     pend_glob <= 1'b0;
    else if (rst_req && sys_rst_no)  pend_glob <= rst_glob_req;
  end

  // R8 / R9: pulse lasts exactly RST_CYCLES
  p_pulse_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_no) |-> low_cnt == CW'(RST_CYCLES));

  // R10: pulse is never extended
  p_no_stretch_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_rst_no |-> low_cnt < CW'(RST_CYCLES));

  // R8: a pulse only starts after a command
  p_pulse_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_no) |-> $past(rst_req));

  // R9: defaults in place when the restoring pulse ends
  p_glob_defaults_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sys_rst_no) && pend_glob) |-> (ovr_q == 8'h00 && bank_q == 3'd0 && bank_sel_o == sw_bank_i));

  // R7: storage changes only through a committed write or a reload
  p_ovr_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ovr_q) |-> $past(commit || reload));

  p_bank_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bank_q) |-> $past(commit || reload));
endmodule

bind board_ctl_regs board_ctl_chk #(.RST_CYCLES(RST_CYCLES)) i_board_ctl_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sys_rst_no   (sys_rst_no),
  .bank_sel_o   (bank_sel_o),
  .sw_bank_i    (sw_bank_i),
  .ovr_q        (ovr_q),
  .bank_q       (bank_q),
  .rst_req      (rst_req),
  .rst_glob_req (rst_glob_req),
  .commit       (commit),
  .reload       (reload)
);

// File: tb/test_board_ctl_regs.sv
`timescale 1ns/1ps
module test_board_ctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [2:0]  sw_bank = 3'd3;
  logic [31:0] sw_stat = '0;
  logic [2:0]  bank_sel;
  logic        sys_rst_n;

  int checks = 0, errors = 0;
  int low_run = 0, last_len = 0, pulses = 0;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  board_ctl_regs i_board_ctl_regs (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .sw_bank_i(sw_bank), .sw_stat_i(sw_stat),
    .bank_sel_o(bank_sel), .sys_rst_no(sys_rst_n)
  );

  always @(negedge clk) begin
    if (!sys_rst_n) low_run++;
    else if (low_run != 0) begin
      last_len = low_run;
      pulses++;
      low_run = 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d,
                           input int hold = 4, input logic use_cs = 1'b1);
    @(negedge clk);
    addr = a; wdata = d; cs = use_cs; wr = 1'b1;
    repeat (hold) @(negedge clk);
    wr = 1'b0; cs = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; cs = 1'b1; rd = 1'b1;
    repeat (4) @(negedge clk);
    d = rdata;
    rd = 1'b0; cs = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk("R2 idle rdata", rdata, 8'h00);
    chk("R11 sys_rst_no high", sys_rst_n, 1);
    chk("R11 bank_sel follows switches", bank_sel, 3);
    bus_read(4'h5, v); chk("R3 override reset value", v, 8'h00);
    bus_read(4'h6, v); chk("R6 rcw reset value", v, 8'h1F);
    bus_read(4'h8, v); chk("R11 bank reset value", v, 8'h00);
  endtask

  task automatic t_ids();
    bus_read(4'h0, v); chk("R1 id hi", v, 8'h5A);
    bus_read(4'h1, v); chk("R1 id lo", v, 8'hC3);
    bus_read(4'h2, v); chk("R1 major", v, 8'h01);
    bus_read(4'h3, v); chk("R1 minor", v, 8'h07);
    bus_read(4'h4, v); chk("R1 board rev", v, 8'h0B);
    bus_write(4'h2, 8'hFF);
    bus_read(4'h2, v); chk("R1 read-only after write", v, 8'h01);
  endtask

  task automatic t_unused();
    bus_write(4'h7, 8'h55);
    bus_write(4'hF, 8'hAA);
    bus_read(4'h7, v); chk("R2 offset 7 reads zero", v, 8'h00);
    bus_read(4'hF, v); chk("R2 offset F reads zero", v, 8'h00);
  endtask

  task automatic t_switches();
    sw_stat = 32'hA1B2_C3D4;
    repeat (3) @(negedge clk);
    bus_read(4'h9, v); chk("R5 switch byte 0", v, 8'hD4);
    bus_read(4'hA, v); chk("R5 switch byte 1", v, 8'hC3);
    bus_read(4'hB, v); chk("R5 switch byte 2", v, 8'hB2);
    bus_read(4'hC, v); chk("R5 switch byte 3", v, 8'hA1);
    sw_stat = 32'h0F1E_2D3C;
    repeat (3) @(negedge clk);
    bus_read(4'h9, v); chk("R5 switch byte 0 second pattern", v, 8'h3C);
    bus_read(4'hC, v); chk("R5 switch byte 3 second pattern", v, 8'h0F);
  endtask

  task automatic t_bank_override();
    sw_bank = 3'd3;
    bus_write(4'h8, 8'hF6);
    bus_read(4'h8, v); chk("R4 bank upper bits zero", v, 8'h06);
    chk("R4 no override keeps switch bank", bank_sel, 3);
    bus_write(4'h5, 8'h04);
    bus_read(4'h5, v); chk("R3 override readback", v, 8'h04);
    chk("R4 override selects software bank", bank_sel, 6);
    bus_write(4'h5, 8'h03);
    chk("R3 bit2 clear returns to switches", bank_sel, 3);
    bus_write(4'h6, 8'h5C);
    bus_read(4'h6, v); chk("R6 rcw readback", v, 8'h5C);
  endtask

  task automatic t_cs_gate();
    bus_write(4'h6, 8'h99, 4, 1'b0);
    bus_read(4'h6, v); chk("R7 write without chip select ignored", v, 8'h5C);
  endtask

  task automatic t_keep_reset();
    int p0;
    bus_write(4'h8, 8'h05);
    bus_write(4'h5, 8'h04);
    p0 = pulses;
    bus_write(4'hD, 8'h01);
    repeat (30) @(negedge clk);
    chk("R8 one preserving pulse", pulses, p0 + 1);
    chk("R8 pulse length", last_len, 16);
    bus_read(4'h5, v); chk("R8 override kept", v, 8'h04);
    bus_read(4'h8, v); chk("R8 bank kept", v, 8'h05);
    chk("R8 bank_sel kept", bank_sel, 5);
    p0 = pulses;
    bus_write(4'hD, 8'h02);
    repeat (30) @(negedge clk);
    chk("R8 other code no pulse", pulses, p0);
  endtask

  task automatic t_held_strobe();
    int p0;
    p0 = pulses;
    bus_write(4'hD, 8'h01, 50);
    repeat (30) @(negedge clk);
    chk("R7 long strobe commits once", pulses, p0 + 1);
  endtask

  task automatic t_global_reset();
    int p0;
    sw_bank = 3'd2;
    p0 = pulses;
    bus_write(4'hE, 8'h00);
    bus_write(4'hE, 8'h00);
    bus_write(4'hD, 8'h01);
    repeat (40) @(negedge clk);
    chk("R10 commands during pulse ignored", pulses, p0 + 1);
    chk("R10 pulse not stretched", last_len, 16);
    bus_read(4'h5, v); chk("R9 override default", v, 8'h00);
    bus_read(4'h8, v); chk("R9 bank default", v, 8'h00);
    bus_read(4'h6, v); chk("R9 rcw default", v, 8'h1F);
    chk("R9 bank_sel back to switches", bank_sel, 2);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_ids();
    t_unused();
    t_switches();
    t_bank_override();
    t_cs_gate();
    t_keep_reset();
    t_held_strobe();
    t_global_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule